// File: doc/BRIEF.md
# Ramp-Compare ADC Conversion Sequencer

This block runs one conversion cycle for an external array of ramp-compare (Wilkinson) converters. An upstream controller pulses `start`. The sequencer then does four things in order:

- it clears the converters' data registers and their shared Gray-code counter;
- it waits a programmable settling time;
- it runs the ramp and the counter clock for a full 12-bit count;
- it stops both together and pulses `done` for the downstream transfer logic.

While a cycle is in progress, `hold` keeps the sampling array frozen.

The ramp length is not set by a dedicated down-counter. It comes from a 16-bit sequence counter that advances on every rising edge of the counter clock, and its bit 12 marks completion. When a cycle ends, that counter is wiped by a clear pulse lasting one slow clock, which is two system clocks. An external event clear also wipes it, and it aborts any cycle in progress.

The counter clock runs at half the system clock. Its rising edges are the count events, so a full count of 4096 takes 8192 system clocks.

Top module: `wilk_conv_seq`

## Requirements
- R1: While `rst` is high and after it is released with no start, all outputs (`reg_clr`, `gcnt_clr`, `ramp_en`, `gcnt_clk`, `hold`, `busy`, `done`) are 0.
- R2: A `start` sampled high at a clock edge while idle raises `reg_clr` and `gcnt_clr` at that edge. Both stay high for exactly 2 clocks, and `ramp_en` is 0 while they are high.
- R3: `ramp_en` rises D clocks after the clears fall. D is `settle_dly` captured at the start edge, and a value of 0 is treated as 1. Changing `settle_dly` later in the cycle has no effect.
- R4: `ramp_en` stays high for exactly 8192 clocks, which is 4096 counter-clock periods, then falls.
- R5: `gcnt_clk` is 0 when the ramp begins and toggles on every clock while `ramp_en` is high, giving 4096 rising edges. It is 0 whenever `ramp_en` is 0.
- R6: `done` is a one-clock pulse on the clock where `ramp_en` falls. It is generated when bit 12 of the 16-bit sequence counter is set.
- R7: The sequence counter is cleared by a 2-clock pulse that begins with `done`. The block stays busy during that pulse, is idle after it, and the next conversion again has full length.
- R8: `hold` (1 = hold, 0 = sample) and `busy` are 1 from the start edge until the block returns to idle, and 0 otherwise.
- R9: A `start` sampled while `busy` is 1 is ignored: the cycle in progress keeps its timing.
- R10: `evt_clr` sampled high at any edge returns the block to idle with all outputs 0 and no `done`, and it zeroes the sequence counter. It takes priority over a simultaneous `start`. A later conversion has full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion launch strobe from the upstream controller |
| evt_clr | input | 1 | External event clear; aborts the cycle and wipes the sequence counter |
| settle_dly | input | DLY_W | Clear-to-ramp settling delay in clocks (0 acts as 1) |
| reg_clr | output | 1 | Converter data-register clear |
| gcnt_clr | output | 1 | Gray-code counter clear |
| ramp_en | output | 1 | Ramp control, 0 = discharge, 1 = ramp |
| gcnt_clk | output | 1 | Gray-code counter clock, counts on rising edge |
| hold | output | 1 | Array control, 0 = sampling, 1 = hold |
| busy | output | 1 | High while a cycle is in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit sequence counter, a 12-bit ramp, and a 4-bit delay input. The full 8192-clock ramp and the bit-12 completion point are therefore exercised exactly as specified, and several complete conversions fit in the run.

Settling delays of 0, 1, 4 and 15 reach both ends of the delay range. Back-to-back conversions show that the 2-clock wipe restores full ramp length.

Event clears are applied during the clear phase and mid-ramp, and one of them coincides with a start. This exposes abort priority and counter wiping at the ports.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_SETTLE,
        ST_RAMP,
        ST_WIPE
    } wcs_state_e;

    typedef struct packed {
        logic reg_clr;
        logic gcnt_clr;
        logic ramp_en;
        logic gcnt_clk;
        logic hold;
        logic done;
    } wcs_drive_t;

    // System clocks spent with the ramp enabled: two per counter-clock period.
    function automatic int unsigned ramp_sys_clks(input int unsigned bits);
        return 32'd2 << bits;
    endfunction

endpackage

// File: rtl/wcs_settle_timer.sv
module wcs_settle_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q <= W'(1));
endmodule

// File: rtl/wcs_seq_counter.sv
module wcs_seq_counter #(
    parameter int CNT_W = 16,
    parameter int TAP   = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic full
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign full = cnt_q[TAP];
endmodule

// File: rtl/wcs_ctrl.sv
module wcs_ctrl
    import wcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       evt_clr,
    input  logic       settle_exp,
    input  logic       seq_full,
    output wcs_drive_t drv,
    output logic       busy,
    output logic       tmr_load,
    output logic       tmr_step,
    output logic       seq_inc,
    output logic       seq_clr
);
    wcs_state_e state_q;
    logic       ph_q;
    wcs_drive_t drv_q;

    always_ff @(posedge clk) begin
        if (rst || evt_clr) begin
            state_q <= ST_IDLE;
            ph_q    <= 1'b0;
            drv_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    drv_q.done <= 1'b0;
                    if (start) begin
                        state_q        <= ST_CLEAR;
                        ph_q           <= 1'b0;
                        drv_q.reg_clr  <= 1'b1;
                        drv_q.gcnt_clr <= 1'b1;
                        drv_q.hold     <= 1'b1;
                    end
                end
                ST_CLEAR: begin
                    if (ph_q) begin
                        state_q        <= ST_SETTLE;
                        ph_q           <= 1'b0;
                        drv_q.reg_clr  <= 1'b0;
                        drv_q.gcnt_clr <= 1'b0;
                    end else begin
                        ph_q <= 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (settle_exp) begin
                        state_q        <= ST_RAMP;
                        drv_q.ramp_en  <= 1'b1;
                        drv_q.gcnt_clk <= 1'b0;
                    end
                end
                ST_RAMP: begin
                    if (seq_full && drv_q.gcnt_clk) begin
                        state_q        <= ST_WIPE;
                        ph_q           <= 1'b0;
                        drv_q.ramp_en  <= 1'b0;
                        drv_q.gcnt_clk <= 1'b0;
                        drv_q.done     <= 1'b1;
                    end else begin
                        drv_q.gcnt_clk <= ~drv_q.gcnt_clk;
                    end
                end
                ST_WIPE: begin
                    drv_q.done <= 1'b0;
                    if (ph_q) begin
                        state_q    <= ST_IDLE;
                        ph_q       <= 1'b0;
                        drv_q.hold <= 1'b0;
                    end else begin
                        ph_q <= 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    ph_q    <= 1'b0;
                    drv_q   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        drv      = drv_q;
        busy     = (state_q != ST_IDLE);
        tmr_load = (state_q == ST_IDLE) && start;
        tmr_step = (state_q == ST_SETTLE);
        seq_inc  = (state_q == ST_RAMP) && !drv_q.gcnt_clk;
        seq_clr  = (state_q == ST_WIPE) || evt_clr;
    end
endmodule

// File: rtl/wilk_conv_seq.sv
module wilk_conv_seq
    import wcs_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int RAMP_BITS = 12,
    parameter int DLY_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             evt_clr,
    input  logic [DLY_W-1:0] settle_dly,
    output logic             reg_clr,
    output logic             gcnt_clr,
    output logic             ramp_en,
    output logic             gcnt_clk,
    output logic             hold,
    output logic             busy,
    output logic             done
);
    localparam int TAP = (RAMP_BITS < CNT_W) ? RAMP_BITS : CNT_W - 1;

    wcs_drive_t       drv;
    logic             tmr_load, tmr_step, settle_exp;
    logic             seq_inc, seq_clr, seq_full;
    logic [DLY_W-1:0] eff_dly;

    // A zero delay still leaves one clock between clear release and ramp.
    assign eff_dly = (settle_dly == '0) ? DLY_W'(1) : settle_dly;

    wcs_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .evt_clr    (evt_clr),
        .settle_exp (settle_exp),
        .seq_full   (seq_full),
        .drv        (drv),
        .busy       (busy),
        .tmr_load   (tmr_load),
        .tmr_step   (tmr_step),
        .seq_inc    (seq_inc),
        .seq_clr    (seq_clr)
    );

    wcs_settle_timer #(.W(DLY_W)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (eff_dly),
        .step     (tmr_step),
        .expired  (settle_exp)
    );

    wcs_seq_counter #(.CNT_W(CNT_W), .TAP(TAP)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .clr  (seq_clr),
        .inc  (seq_inc),
        .full (seq_full)
    );

    assign reg_clr  = drv.reg_clr;
    assign gcnt_clr = drv.gcnt_clr;
    assign ramp_en  = drv.ramp_en;
    assign gcnt_clk = drv.gcnt_clk;
    assign hold     = drv.hold;
    assign done     = drv.done;
endmodule

// File: rtl/wcs_checker.sv
module wcs_checker
    import wcs_pkg::*;
#(
    parameter int RAMP_BITS = 12
) (
    input logic clk,
    input logic rst,
    input logic evt_clr,
    input logic reg_clr,
    input logic gcnt_clr,
    input logic ramp_en,
    input logic gcnt_clk,
    input logic hold,
    input logic busy,
    input logic done
);
    localparam int unsigned RAMP_CLKS = ramp_sys_clks(RAMP_BITS);

    logic [31:0] ramp_cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !ramp_en) ramp_cnt_q <= '0;
        else                 ramp_cnt_q <= ramp_cnt_q + 1'b1;
    end

    p_clr_in_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_clr || gcnt_clr) |-> (hold && !ramp_en));

    p_ramp_after_clr_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ramp_en) |-> (!reg_clr && !gcnt_clr && !$past(reg_clr)));

    p_ramp_len_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(ramp_en) && done) |-> (ramp_cnt_q == RAMP_CLKS));

    p_gclk_gated_r5: assert property (@(posedge clk) disable iff (rst)
        gcnt_clk |-> ramp_en);

    p_gclk_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        (ramp_en && $past(ramp_en)) |-> (gcnt_clk != $past(gcnt_clk)));

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_at_ramp_end_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(ramp_en) && !ramp_en));

    p_hold_tracks_busy_r8: assert property (@(posedge clk) disable iff (rst)
        hold == busy);

    p_evt_abort_r10: assert property (@(posedge clk) disable iff (rst)
        $past(evt_clr) |-> (!busy && !ramp_en && !done && !reg_clr));
endmodule

bind wilk_conv_seq wcs_checker #(.RAMP_BITS(RAMP_BITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .evt_clr  (evt_clr),
    .reg_clr  (reg_clr),
    .gcnt_clr (gcnt_clr),
    .ramp_en  (ramp_en),
    .gcnt_clk (gcnt_clk),
    .hold     (hold),
    .busy     (busy),
    .done     (done)
);

// File: tb/wilk_conv_seq_tb.sv
module wilk_conv_seq_tb;
    localparam int RC = 2 * (1 << 12);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       evt_clr = 1'b0;
    logic [3:0] settle_dly = 4'd4;
    logic reg_clr, gcnt_clr, ramp_en, gcnt_clk, hold, busy, done;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit fin = 1'b0;

    int n = -1;
    int md = 1;

    always #5 clk = ~clk;

    wilk_conv_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .evt_clr(evt_clr),
        .settle_dly(settle_dly), .reg_clr(reg_clr), .gcnt_clr(gcnt_clr),
        .ramp_en(ramp_en), .gcnt_clk(gcnt_clk), .hold(hold), .busy(busy),
        .done(done)
    );

    task automatic chk(input int act, input int exp, input string tag);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference: n = edges since the accepted start, -1 when idle.
    always @(posedge clk) begin
        cyc++;
        if (rst || evt_clr) begin
            n = -1;
        end else if (n < 0) begin
            if (start) begin
                n  = 0;
                md = (settle_dly == 0) ? 1 : int'(settle_dly);
            end
        end else begin
            n++;
            if (n == 4 + md + RC) n = -1;
        end
        if (cyc > 150000 && !fin) begin
            fails++;
            $display("FAIL watchdog expired, act=running exp=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!fin) begin
            bit e_clr, e_ramp, e_gclk, e_done, e_busy;
            e_busy = (n >= 0);
            e_clr  = (n == 0) || (n == 1);
            e_ramp = (n >= 2 + md) && (n <= 1 + md + RC);
            e_gclk = e_ramp && (((n - 2 - md) % 2) == 1);
            e_done = (n == 2 + md + RC);
            chk(int'(reg_clr),  int'(e_clr),  "R2 reg_clr");
            chk(int'(gcnt_clr), int'(e_clr),  "R2 gcnt_clr");
            chk(int'(ramp_en),  int'(e_ramp), "R4 ramp_en");
            chk(int'(gcnt_clk), int'(e_gclk), "R5 gcnt_clk");
            chk(int'(done),     int'(e_done), "R6 done");
            chk(int'(hold),     int'(e_busy), "R8 hold");
            chk(int'(busy),     int'(e_busy), "R8 busy");
        end
    end

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // Launches a conversion and returns the negedge count until done is seen.
    task automatic run_conv(input logic [3:0] d, output int cnt);
        settle_dly = d;
        start = 1'b1;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1)   start = 1'b0;
            if (cnt == 100) start = 1'b1;      // ignored while busy
            if (cnt == 101) start = 1'b0;
            if (cnt == 102) settle_dly = 4'd9; // must not alter this cycle
        end while (!done && cnt < 20000);
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        chk(int'({reg_clr, gcnt_clr, ramp_en, gcnt_clk, hold, busy, done}), 0, "R1 in reset");
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(int'({reg_clr, gcnt_clr, ramp_en, gcnt_clk, hold, busy, done}), 0, "R1 after reset");

        // R3: delay 4 -> ramp visible after edge 6, not after edge 5
        settle_dly = 4'd4;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        chk(int'(ramp_en), 0, "R3 ramp before delay");
        @(negedge clk);
        chk(int'(ramp_en), 1, "R3 ramp after delay");
        while (!done) @(negedge clk);
        wait_idle();

        run_conv(4'd4, c);
        chk(c, 3 + 4 + RC, "R6 done timing d=4");
        repeat (4) @(negedge clk);
        chk(int'(busy), 0, "R9 no restart from ignored start");

        wait_idle();
        run_conv(4'd0, c);
        chk(c, 3 + 1 + RC, "R3 zero delay acts as one");
        wait_idle();
        run_conv(4'd1, c);
        chk(c, 3 + 1 + RC, "R7 back-to-back full length");

        // R10: abort during clear phase
        wait_idle();
        @(negedge clk);
        settle_dly = 4'd2; start = 1'b1;
        @(negedge clk); start = 1'b0; evt_clr = 1'b1;
        @(negedge clk); evt_clr = 1'b0;
        chk(int'(busy), 0, "R10 abort in clear");
        chk(int'(reg_clr), 0, "R10 clear dropped");

        // R10: abort mid-ramp together with a start
        settle_dly = 4'd2; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3000) @(negedge clk);
        evt_clr = 1'b1; start = 1'b1;
        @(negedge clk); evt_clr = 1'b0; start = 1'b0;
        chk(int'(busy), 0, "R10 evt_clr beats start");
        chk(int'(ramp_en), 0, "R10 ramp stopped");
        repeat (2) @(negedge clk);
        chk(int'(done), 0, "R10 no done after abort");

        run_conv(4'd15, c);
        chk(c, 3 + 15 + RC, "R10 full length after abort");
        wait_idle();
        repeat (3) @(negedge clk);
        chk(int'(hold), 0, "R8 hold back to sampling");

        fin = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule